// File: doc/BRIEF.md
# Configurable Macrocell Storage Element

This block is one storage bit of a programmable sum-of-products cell. Static configuration inputs choose where its data comes from, how the bit is updated, and what clocks and asynchronously clears or sets it. Product-term generation and routing sit outside the block. It sees their results only as single-bit inputs. The configuration is read continuously, so a change takes effect at once.

The storage can act as a D, T, JK or SR flip-flop that updates on a rising edge. It can also act as a level-sensitive latch that is transparent while its gate is high. The edge or gate comes from either the shared global clock or a per-cell product term. A product-term clock enable applies only to the global clock. The cell clears from the global clear, from a product term, from both combined by OR, or from neither. It sets from a product term or from nothing. A clear always overrides a set.

Top module: `mc_store_cell`

## Requirements
- R1: `cfg_dsel` picks the data bit. 0 selects `xor_in`, 1 selects `pt_data`, 2 selects `pin_in`, and 3 behaves like 0.
- R2: With `cfg_mode`=0 (D), or any code from 5 to 7, `q` takes the selected data bit on each enabled rising edge.
- R3: With `cfg_mode`=1 (T), the selected data bit is the toggle input. If it is 1, `q` inverts on an enabled edge. If it is 0, `q` holds.
- R4: With `cfg_mode`=2 (JK), J is the selected data bit and K is `pt_aux`. On an enabled edge, 00 holds, 10 sets, 01 clears and 11 toggles.
- R5: With `cfg_mode`=3 (SR), S is the selected data bit and R is `pt_aux`. On an enabled edge, 10 sets, 01 clears, and both 00 and 11 hold.
- R6: With `cfg_mode`=4 (latch), `q` follows the selected data bit while the enabled clock is high. It holds while the clock is low.
- R7: `cfg_csel`=0 uses `gclk` as the clock and `cfg_csel`=1 uses `pt_clk`. Edges of the clock that is not selected have no effect.
- R8: When `cfg_csel`=0 and `cfg_ce_en`=1, a low `pt_ce` makes the cell ignore every clock edge. When `cfg_csel`=1, `pt_ce` has no effect.
- R9: `cfg_rsel` picks the clear source: 0 none, 1 `gclr`, 2 `pt_rst`, 3 the OR of `gclr` and `pt_rst`. An active clear drives `q` to 0 at once, without waiting for a clock.
- R10: With `cfg_psel`=1, a high `pt_pre` drives `q` to 1 at once. With `cfg_psel`=0, `pt_pre` has no effect.
- R11: When a clear and a set are active together, `q` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 1 | Global clock |
| gclr | input | 1 | Global clear, active high |
| xor_in | input | 1 | XOR-gate data source |
| pt_data | input | 1 | Dedicated product-term data source |
| pin_in | input | 1 | Pin data source |
| pt_aux | input | 1 | Second operand: K in JK mode, R in SR mode |
| pt_clk | input | 1 | Product-term clock |
| pt_ce | input | 1 | Product-term clock enable |
| pt_rst | input | 1 | Product-term clear |
| pt_pre | input | 1 | Product-term set |
| cfg_dsel | input | 2 | Data source select |
| cfg_mode | input | 3 | Storage mode |
| cfg_csel | input | 1 | Clock source select |
| cfg_ce_en | input | 1 | Use pt_ce as enable on the global clock |
| cfg_rsel | input | 2 | Clear source select |
| cfg_psel | input | 1 | Set source select |
| q | output | 1 | Stored bit |

## Verification
The hardest cases to reach are the ones that depend on timing between clock edges. Examples are the latch's transparent window and a clear or set arriving mid-cycle. Another is a product-term clock edge that must ignore a low enable.

To reach them, the bench drives `pt_clk`, `pt_rst` and `pt_pre` directly as short pulses placed between global clock edges. It samples `q` a few time units after each pulse. It also drives data changes during both the high and the low phase of the latch gate.

// File: rtl/mc_store_pkg.sv
package mc_store_pkg;
   localparam int DSEL_W = 2;
   localparam int MODE_W = 3;
   localparam int RSEL_W = 2;

   typedef enum logic [DSEL_W-1:0] {
      DSRC_XOR = 2'd0,
      DSRC_PT  = 2'd1,
      DSRC_PIN = 2'd2,
      DSRC_ALT = 2'd3
   } dsrc_e;

   typedef enum logic [MODE_W-1:0] {
      MODE_D     = 3'd0,
      MODE_T     = 3'd1,
      MODE_JK    = 3'd2,
      MODE_SR    = 3'd3,
      MODE_LATCH = 3'd4
   } smode_e;

   typedef enum logic [RSEL_W-1:0] {
      CLR_NONE = 2'd0,
      CLR_GLB  = 2'd1,
      CLR_PT   = 2'd2,
      CLR_BOTH = 2'd3
   } clrsrc_e;
endpackage

// File: rtl/mc_src_sel.sv
module mc_src_sel
   import mc_store_pkg::*;
(
   input  logic              gclk,
   input  logic              gclr,
   input  logic              xor_in,
   input  logic              pt_data,
   input  logic              pin_in,
   input  logic              pt_clk,
   input  logic              pt_ce,
   input  logic              pt_rst,
   input  logic              pt_pre,
   input  logic [DSEL_W-1:0] cfg_dsel,
   input  logic              cfg_csel,
   input  logic              cfg_ce_en,
   input  logic [RSEL_W-1:0] cfg_rsel,
   input  logic              cfg_psel,
   output logic              d_sel,
   output logic              clk_eff,
   output logic              ce_eff,
   output logic              clr_a,
   output logic              set_a
);
   always_comb begin
      unique case (dsrc_e'(cfg_dsel))
         DSRC_PT:  d_sel = pt_data;
         DSRC_PIN: d_sel = pin_in;
         default:  d_sel = xor_in;
      endcase
   end

   assign clk_eff = cfg_csel ? pt_clk : gclk;
   assign ce_eff  = (!cfg_csel && cfg_ce_en) ? pt_ce : 1'b1;

   always_comb begin
      unique case (clrsrc_e'(cfg_rsel))
         CLR_GLB:  clr_a = gclr;
         CLR_PT:   clr_a = pt_rst;
         CLR_BOTH: clr_a = gclr | pt_rst;
         default:  clr_a = 1'b0;
      endcase
   end

   assign set_a = cfg_psel & pt_pre;
endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
   import mc_store_pkg::*;
(
   input  logic [MODE_W-1:0] mode,
   input  logic              cur,
   input  logic              op_a,
   input  logic              op_b,
   output logic              nxt
);
   always_comb begin
      unique case (smode_e'(mode))
         MODE_T:  nxt = cur ^ op_a;
         MODE_JK: nxt = (op_a & ~cur) | (~op_b & cur);
         MODE_SR: begin
            if (op_a && !op_b)      nxt = 1'b1;
            else if (op_b && !op_a) nxt = 1'b0;
            else                    nxt = cur;
         end
         default: nxt = op_a;
      endcase
   end
endmodule

// File: rtl/mc_store_cell.sv
module mc_store_cell
   import mc_store_pkg::*;
#(
   parameter bit LATCH_EN = 1'b1
)(
   input  logic              gclk,
   input  logic              gclr,
   input  logic              xor_in,
   input  logic              pt_data,
   input  logic              pin_in,
   input  logic              pt_aux,
   input  logic              pt_clk,
   input  logic              pt_ce,
   input  logic              pt_rst,
   input  logic              pt_pre,
   input  logic [DSEL_W-1:0] cfg_dsel,
   input  logic [MODE_W-1:0] cfg_mode,
   input  logic              cfg_csel,
   input  logic              cfg_ce_en,
   input  logic [RSEL_W-1:0] cfg_rsel,
   input  logic              cfg_psel,
   output logic              q
);
   logic d_sel, clk_eff, ce_eff, clr_a, set_a;
   logic nxt, ff_q, lat_q;

   mc_src_sel u_sel (
      .gclk(gclk), .gclr(gclr), .xor_in(xor_in), .pt_data(pt_data),
      .pin_in(pin_in), .pt_clk(pt_clk), .pt_ce(pt_ce), .pt_rst(pt_rst),
      .pt_pre(pt_pre), .cfg_dsel(cfg_dsel), .cfg_csel(cfg_csel),
      .cfg_ce_en(cfg_ce_en), .cfg_rsel(cfg_rsel), .cfg_psel(cfg_psel),
      .d_sel(d_sel), .clk_eff(clk_eff), .ce_eff(ce_eff),
      .clr_a(clr_a), .set_a(set_a)
   );

   mc_next_state u_nxt (
      .mode(cfg_mode), .cur(ff_q), .op_a(d_sel), .op_b(pt_aux), .nxt(nxt)
   );

   // edge-triggered store; clear checked before set
   always_ff @(posedge clk_eff or posedge clr_a or posedge set_a) begin
      if (clr_a)       ff_q <= 1'b0;
      else if (set_a)  ff_q <= 1'b1;
      else if (ce_eff) ff_q <= nxt;
   end

   generate
      if (LATCH_EN) begin : g_latch
         always_latch begin
            if (clr_a)                  lat_q <= 1'b0;
            else if (set_a)             lat_q <= 1'b1;
            else if (clk_eff && ce_eff) lat_q <= d_sel;
         end
         assign q = (smode_e'(cfg_mode) == MODE_LATCH) ? lat_q : ff_q;
      end else begin : g_nolatch
         assign lat_q = 1'b0;
         assign q     = ff_q;
      end
   endgenerate
endmodule

// File: rtl/mc_store_cell_chk.sv
module mc_store_cell_chk
   import mc_store_pkg::*;
(
   input logic              gclk,
   input logic              gclr,
   input logic              xor_in,
   input logic              pt_data,
   input logic              pin_in,
   input logic              pt_ce,
   input logic              pt_rst,
   input logic              pt_pre,
   input logic [DSEL_W-1:0] cfg_dsel,
   input logic [MODE_W-1:0] cfg_mode,
   input logic              cfg_csel,
   input logic              cfg_ce_en,
   input logic [RSEL_W-1:0] cfg_rsel,
   input logic              cfg_psel,
   input logic              q
);
   logic armed = 1'b0;
   logic rst_on, pre_on, dval;

   assign rst_on = (cfg_rsel[0] & gclr) | (cfg_rsel[1] & pt_rst);
   assign pre_on = cfg_psel & pt_pre;
   assign dval   = (cfg_dsel == 2'd1) ? pt_data :
                   (cfg_dsel == 2'd2) ? pin_in : xor_in;

   always_ff @(posedge gclk) if (rst_on) armed <= 1'b1;

   // R9
   clear_forces_zero_chk: assert property (@(negedge gclk) disable iff (!armed)
      rst_on |-> (q == 1'b0));

   // R10
   set_forces_one_chk: assert property (@(negedge gclk) disable iff (!armed)
      (pre_on && !rst_on) |-> (q == 1'b1));

   // R2
   d_capture_chk: assert property (@(posedge gclk) disable iff (!armed)
      (cfg_mode == 3'd0 && !cfg_csel && !cfg_ce_en && !rst_on && !pre_on)
      |=> (rst_on || pre_on || !$stable(cfg_mode) || !$stable(cfg_csel)
           || q == $past(dval)));

   // R8
   enable_hold_chk: assert property (@(posedge gclk) disable iff (!armed)
      (!cfg_csel && cfg_ce_en && !pt_ce && cfg_mode != 3'd4 && !rst_on && !pre_on)
      |=> (rst_on || pre_on || !$stable(cfg_mode) || !$stable(cfg_csel)
           || q == $past(q)));
endmodule

bind mc_store_cell mc_store_cell_chk u_chk (
   .gclk(gclk), .gclr(gclr), .xor_in(xor_in), .pt_data(pt_data),
   .pin_in(pin_in), .pt_ce(pt_ce), .pt_rst(pt_rst), .pt_pre(pt_pre),
   .cfg_dsel(cfg_dsel), .cfg_mode(cfg_mode), .cfg_csel(cfg_csel),
   .cfg_ce_en(cfg_ce_en), .cfg_rsel(cfg_rsel), .cfg_psel(cfg_psel), .q(q)
);

// File: tb/mc_store_cell_test.sv
`timescale 1ns/1ps
module mc_store_cell_test;
   localparam int CLK_P = 10;

   logic gclk = 1'b0, gclr, xor_in, pt_data, pin_in, pt_aux;
   logic pt_clk, pt_ce, pt_rst, pt_pre;
   logic [1:0] cfg_dsel, cfg_rsel;
   logic [2:0] cfg_mode;
   logic cfg_csel, cfg_ce_en, cfg_psel;
   logic q;
   int n_run = 0, n_fail = 0;

   always #(CLK_P/2) gclk = ~gclk;

   mc_store_cell uut (
      .gclk(gclk), .gclr(gclr), .xor_in(xor_in), .pt_data(pt_data),
      .pin_in(pin_in), .pt_aux(pt_aux), .pt_clk(pt_clk), .pt_ce(pt_ce),
      .pt_rst(pt_rst), .pt_pre(pt_pre), .cfg_dsel(cfg_dsel),
      .cfg_mode(cfg_mode), .cfg_csel(cfg_csel), .cfg_ce_en(cfg_ce_en),
      .cfg_rsel(cfg_rsel), .cfg_psel(cfg_psel), .q(q)
   );

   task automatic check(input string req, input logic exp);
      n_run++;
      if (q !== exp) begin
         n_fail++;
         $display("FAIL %s: q=%b expected %b at %0t", req, q, exp, $time);
      end
   endtask

   // one global edge, then return at the following falling edge
   task automatic step();
      @(posedge gclk);
      @(negedge gclk);
   endtask

   task automatic pt_pulse();
      pt_clk = 1'b1; #2; pt_clk = 1'b0; #1;
   endtask

   task automatic t_reset();
      gclr = 1'b1; cfg_rsel = 2'd1;
      step(); step();
      check("R9 global clear", 1'b0);
      gclr = 1'b0;
   endtask

   task automatic t_dsel();
      cfg_mode = 3'd0; cfg_dsel = 2'd0; xor_in = 1'b1; pt_data = 1'b0; pin_in = 1'b0;
      step(); check("R1 R2 xor source", 1'b1);
      cfg_dsel = 2'd1; step(); check("R1 R2 pt source", 1'b0);
      cfg_dsel = 2'd2; pin_in = 1'b1; step(); check("R1 R2 pin source", 1'b1);
      cfg_dsel = 2'd3; xor_in = 1'b0; step(); check("R1 code 3 acts as xor", 1'b0);
      cfg_mode = 3'd6; cfg_dsel = 2'd2; step(); check("R2 spare mode acts as D", 1'b1);
   endtask

   task automatic t_toggle();
      cfg_mode = 3'd1; cfg_dsel = 2'd1; pt_data = 1'b1;
      step(); check("R3 toggle", 1'b0);
      step(); check("R3 toggle", 1'b1);
      pt_data = 1'b0; step(); check("R3 hold", 1'b1);
   endtask

   task automatic t_jk();
      cfg_mode = 3'd2; cfg_dsel = 2'd1;
      pt_data = 1'b0; pt_aux = 1'b1; step(); check("R4 clear", 1'b0);
      pt_data = 1'b0; pt_aux = 1'b0; step(); check("R4 hold", 1'b0);
      pt_data = 1'b1; pt_aux = 1'b0; step(); check("R4 set", 1'b1);
      pt_data = 1'b1; pt_aux = 1'b1; step(); check("R4 toggle", 1'b0);
      step(); check("R4 toggle", 1'b1);
   endtask

   task automatic t_sr();
      cfg_mode = 3'd3; cfg_dsel = 2'd1;
      pt_data = 1'b0; pt_aux = 1'b1; step(); check("R5 clear", 1'b0);
      pt_data = 1'b1; pt_aux = 1'b0; step(); check("R5 set", 1'b1);
      pt_data = 1'b1; pt_aux = 1'b1; step(); check("R5 both hold", 1'b1);
      pt_data = 1'b0; pt_aux = 1'b0; step(); check("R5 none hold", 1'b1);
      pt_aux = 1'b0;
   endtask

   task automatic t_enable();
      cfg_mode = 3'd0; cfg_dsel = 2'd1; cfg_ce_en = 1'b1; pt_ce = 1'b0; pt_data = 1'b0;
      step(); check("R8 edge ignored", 1'b1);
      pt_ce = 1'b1; step(); check("R8 edge enabled", 1'b0);
      pt_ce = 1'b0; pt_data = 1'b1; step(); check("R8 edge ignored", 1'b0);
      cfg_csel = 1'b1; step(); check("R7 gclk ignored", 1'b0);
      pt_pulse(); check("R8 enable ignored on pt clock", 1'b1);
      cfg_ce_en = 1'b0; pt_ce = 1'b1;
   endtask

   task automatic t_ptclk();
      pt_data = 1'b0; step(); step(); check("R7 gclk ignored", 1'b1);
      pt_pulse(); check("R7 pt clock edge", 1'b0);
      pt_data = 1'b1; pt_pulse(); check("R7 pt clock edge", 1'b1);
   endtask

   task automatic t_async();
      cfg_rsel = 2'd2; pt_rst = 1'b1; #1; check("R9 pt clear", 1'b0);
      pt_rst = 1'b0; pt_pulse(); check("R7 reload", 1'b1);
      cfg_rsel = 2'd3; gclr = 1'b1; #1; check("R9 or-clear via gclr", 1'b0);
      gclr = 1'b0; pt_pulse();
      pt_rst = 1'b1; #1; check("R9 or-clear via pt", 1'b0);
      pt_rst = 1'b0; pt_pulse();
      cfg_rsel = 2'd0; gclr = 1'b1; pt_rst = 1'b1; #1; check("R9 clear disabled", 1'b1);
      gclr = 1'b0; pt_rst = 1'b0; cfg_rsel = 2'd1;
      pt_data = 1'b0; pt_pulse(); check("R7 reload", 1'b0);
      cfg_psel = 1'b1; pt_pre = 1'b1; #1; check("R10 pt set", 1'b1);
      pt_pre = 1'b0; #1; check("R10 set released", 1'b1);
      pt_pulse(); check("R7 reload", 1'b0);
      cfg_psel = 1'b0; pt_pre = 1'b1; #1; check("R10 set disabled", 1'b0);
      pt_pre = 1'b0; pt_data = 1'b1; pt_pulse();
      cfg_psel = 1'b1; gclr = 1'b1; pt_pre = 1'b1; #1; check("R11 clear beats set", 1'b0);
      pt_pre = 1'b0; #1; gclr = 1'b0; cfg_psel = 1'b0;
   endtask

   task automatic t_latch();
      @(negedge gclk);
      cfg_mode = 3'd4; cfg_dsel = 2'd1; pt_data = 1'b1; pt_clk = 1'b1; #1;
      check("R6 open follows", 1'b1);
      pt_data = 1'b0; #1; check("R6 open follows", 1'b0);
      pt_clk = 1'b0; #1; pt_data = 1'b1; #1; check("R6 closed holds", 1'b0);
      @(negedge gclk);
      cfg_csel = 1'b0; #2; check("R6 gclk low holds", 1'b0);
      @(posedge gclk); #2; check("R6 gclk high follows", 1'b1);
      pt_data = 1'b0; #1; check("R6 gclk high follows", 1'b0);
      @(negedge gclk); #1; pt_data = 1'b1; #1; check("R6 gclk low holds", 1'b0);
   endtask

   initial begin
      #(CLK_P * 200000);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      gclr = 1'b0; xor_in = 1'b0; pt_data = 1'b0; pin_in = 1'b0; pt_aux = 1'b0;
      pt_clk = 1'b0; pt_ce = 1'b1; pt_rst = 1'b0; pt_pre = 1'b0;
      cfg_dsel = 2'd0; cfg_mode = 3'd0; cfg_csel = 1'b0; cfg_ce_en = 1'b0;
      cfg_rsel = 2'd1; cfg_psel = 1'b0;
      @(negedge gclk);
      t_reset();
      t_dsel();
      t_toggle();
      t_jk();
      t_sr();
      t_enable();
      t_ptclk();
      t_async();
      t_latch();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule